// File: doc/BRIEF.md
# Bit-Sliced Four-Bit Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit. It takes two 4-bit operands and a 3-bit operation code. It returns a 4-bit result, a flag that is high when the result is all zeros, and a flag for two's-complement overflow.

The datapath is a ripple chain of identical one-bit slices. Each slice has:
- a full adder;
- AND and OR gates;
- a conditional inverter on its `b` input;
- a four-way result selector.

Carries travel from the least significant slice upward.

Subtraction reuses the adder. The `b` operand is inverted bit by bit, and the carry into the lowest slice is forced to one. The upper opcode bit drives both of these controls at once. Set-less-than is built from the subtraction path. The sign of the difference is corrected by the overflow term and fed back into the result selector of the lowest slice.

Top module: `alu4_bitslice`

## Requirements
- R1: Opcode 000 gives r = a AND b, bit by bit.
- R2: Opcode 001 gives r = a OR b, bit by bit.
- R3: Opcode 010 gives r = (a + b) mod 16.
- R4: Opcode 110 gives r = (a - b) mod 16, formed as a + NOT b + 1.
- R5: Opcode 111 gives r = 0001 when a is less than b as signed 4-bit numbers, and 0000 otherwise. Bits 3..1 are always 0.
- R6: For opcodes 010 and 110, ovfl is 1 exactly when the signed result does not fit in the range -8..7.
- R7: For opcodes 000, 001 and 111, ovfl is 0.
- R8: zero is 1 exactly when r equals 0000, for every opcode.
- R9: Opcodes 011, 100 and 101 give r = 0000 and ovfl = 0, so zero is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First operand |
| b | input | 4 | Second operand |
| op | input | 3 | Operation code: 000 AND, 001 OR, 010 add, 110 subtract, 111 set-less-than |
| r | output | 4 | Result |
| zero | output | 1 | High when r is all zeros |
| ovfl | output | 1 | Signed overflow of add or subtract |

## Verification
Every one of the 256 operand pairs is applied under each of the eight opcode values. This separates a wrong gate in any single slice from a broken carry ripple, because the carry paths are exercised across all four bit positions.

Directed corner pairs are also applied:
- 7+1 and -8+(-8), which overflow on add;
- -8-1 and 7-(-1), which overflow on subtract;
- equal operands, which give a zero difference;
- -8 against 7.

These corners tell a set-less-than that uses the raw sign bit apart from one that applies the overflow correction. They also show whether the overflow flag is gated off for the logic operations.

The three unused codes are checked with operands that would otherwise give nonzero results. This shows that their outputs are forced to zero.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int WIDTH = 4;
    localparam int OPW   = 3;

    typedef enum logic [OPW-1:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } sel_e;

    typedef struct packed {
        logic en;     // result enable; low for unused codes
        logic binv;   // invert b and force lowest carry-in
        logic arith;  // overflow is reported
        sel_e sel;    // slice result source
    } ctl_t;

    function automatic ctl_t decode_op(input logic [OPW-1:0] code);
        ctl_t c;
        c.en    = 1'b1;
        c.binv  = code[2];
        c.arith = 1'b0;
        c.sel   = sel_e'(code[1:0]);
        case (code)
            OP_AND, OP_OR, OP_SLT: ;
            OP_ADD, OP_SUB:        c.arith = 1'b1;
            default: begin
                c.en  = 1'b0;
                c.sel = SEL_AND;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu4_fadd.sv
module alu4_fadd (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    always_comb begin
        s    = x ^ y ^ cin;
        cout = (cin & x) | (cin & y) | (x & y);
    end
endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
    import alu4_pkg::*;
(
    input  logic ai,
    input  logic bi,
    input  logic ci,
    input  logic less,
    input  ctl_t ctl,
    output logic sum,
    output logic ri,
    output logic co
);
    logic b_eff;

    assign b_eff = bi ^ ctl.binv;

    alu4_fadd u_fadd (
        .x   (ai),
        .y   (b_eff),
        .cin (ci),
        .s   (sum),
        .cout(co)
    );

    always_comb begin
        ri = 1'b0;
        if (ctl.en) begin
            unique case (ctl.sel)
                SEL_AND:  ri = ai & b_eff;
                SEL_OR:   ri = ai | b_eff;
                SEL_SUM:  ri = sum;
                SEL_LESS: ri = less;
            endcase
        end
    end
endmodule

// File: rtl/alu4_flags.sv
module alu4_flags #(
    parameter int W = 4
) (
    input  logic [W-1:0] res,
    input  logic         c_in_msb,
    input  logic         c_out_msb,
    input  logic         msb_sum,
    input  logic         arith,
    output logic         zero,
    output logic         ovfl,
    output logic         lt
);
    logic ov_raw;

    always_comb begin
        ov_raw = c_in_msb ^ c_out_msb;
        lt     = msb_sum ^ ov_raw;
        ovfl   = arith & ov_raw;
        zero   = ~|res;
    end
endmodule

// File: rtl/alu4_bitslice.sv
module alu4_bitslice
    import alu4_pkg::*;
#(
    parameter int W = alu4_pkg::WIDTH
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [OPW-1:0] op,
    output logic [W-1:0]   r,
    output logic           zero,
    output logic           ovfl
);
    ctl_t         ctl;
    logic [W:0]   carry;
    logic [W-1:0] sum_w;
    logic         lt;

    assign ctl      = decode_op(op);
    assign carry[0] = ctl.binv;

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu4_slice u_slice (
            .ai  (a[i]),
            .bi  (b[i]),
            .ci  (carry[i]),
            .less((i == 0) ? lt : 1'b0),
            .ctl (ctl),
            .sum (sum_w[i]),
            .ri  (r[i]),
            .co  (carry[i+1])
        );
    end

    alu4_flags #(.W(W)) u_flags (
        .res      (r),
        .c_in_msb (carry[W-1]),
        .c_out_msb(carry[W]),
        .msb_sum  (sum_w[W-1]),
        .arith    (ctl.arith),
        .zero     (zero),
        .ovfl     (ovfl),
        .lt       (lt)
    );

    always_comb begin
        if (!$isunknown({a, b, op, r, zero, ovfl})) begin
            a_r1_and_bits: assert (op != OP_AND || r == (a & b))
                else $error("R1 and mismatch");
            a_r3_add_mod: assert (op != OP_ADD || r == W'(a + b))
                else $error("R3 add mismatch");
            a_r3_sum_bus: assert (op != OP_ADD || r == sum_w)
                else $error("R3 result mux differs from adder sums");
            a_r4_sub_mod: assert (op != OP_SUB || r == W'(a - b))
                else $error("R4 subtract mismatch");
            a_r5_slt_upper: assert (op != OP_SLT || r[W-1:1] == '0)
                else $error("R5 upper bits not clear");
            a_r5_slt_value: assert (op != OP_SLT || r[0] == ($signed(a) < $signed(b)))
                else $error("R5 less-than mismatch");
            a_r7_no_overflow: assert (!(op == OP_AND || op == OP_OR || op == OP_SLT) || !ovfl)
                else $error("R7 overflow on logic op");
            a_r8_zero_sub: assert (op != OP_SUB || zero == (a == b))
                else $error("R8 zero after subtract");
            a_r9_unused: assert (!(op == 3'b011 || op == 3'b100 || op == 3'b101)
                                 || (r == '0 && !ovfl))
                else $error("R9 unused code active");
        end
    end
endmodule

// File: tb/alu4_bitslice_tb.sv
module alu4_bitslice_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a = '0;
    logic [3:0] b = '0;
    logic [2:0] op = '0;
    logic [3:0] r;
    logic       zero;
    logic       ovfl;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    alu4_bitslice u_dut (
        .a(a), .b(b), .op(op), .r(r), .zero(zero), .ovfl(ovfl)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cycles <= 0;
        else cycles <= cycles + 1;
        if (!done && cycles > 100000) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s op=%b a=%h b=%h actual=%0d expected=%0d",
                     req, what, op, a, b, act, exp);
        end
    endtask

    // Expected values from the requirements only
    task automatic apply(input logic [2:0] oc, input int ia, input int ib,
                         input string req_r, input string req_o);
        int sa, sb, full, er, eo;
        a = ia[3:0]; b = ib[3:0]; op = oc;
        #2;
        sa = (ia > 7) ? ia - 16 : ia;
        sb = (ib > 7) ? ib - 16 : ib;
        er = 0; eo = 0;
        case (oc)
            3'b000: er = ia & ib;
            3'b001: er = ia | ib;
            3'b010: begin full = sa + sb; er = (ia + ib) & 15; eo = (full > 7 || full < -8); end
            3'b110: begin full = sa - sb; er = (ia - ib) & 15; eo = (full > 7 || full < -8); end
            3'b111: er = (sa < sb) ? 1 : 0;
            default: er = 0;
        endcase
        chk(req_r, "r", int'(r), er);
        chk(req_o, "ovfl", int'(ovfl), eo);
        chk("R8", "zero", int'(zero), (er == 0) ? 1 : 0);
        #3;
    endtask

    task automatic sweep(input logic [2:0] oc, input string req_r, input string req_o);
        for (int ia = 0; ia < 16; ia++)
            for (int ib = 0; ib < 16; ib++)
                apply(oc, ia, ib, req_r, req_o);
    endtask

    task automatic t_idle;
        a = '0; b = '0; op = 3'b000; #2;
        chk("R1", "r idle", int'(r), 0);
        chk("R8", "zero idle", int'(zero), 1);
        chk("R7", "ovfl idle", int'(ovfl), 0);
        #3;
    endtask

    task automatic t_and;  sweep(3'b000, "R1", "R7"); endtask
    task automatic t_or;   sweep(3'b001, "R2", "R7"); endtask
    task automatic t_add;  sweep(3'b010, "R3", "R6"); endtask
    task automatic t_sub;  sweep(3'b110, "R4", "R6"); endtask
    task automatic t_slt;  sweep(3'b111, "R5", "R7"); endtask

    task automatic t_unused;
        sweep(3'b011, "R9", "R9");
        sweep(3'b100, "R9", "R9");
        sweep(3'b101, "R9", "R9");
    endtask

    task automatic t_corners;
        apply(3'b010, 7, 1, "R3", "R6");    // 7+1 overflows
        apply(3'b010, 8, 8, "R3", "R6");    // -8 + -8 overflows
        apply(3'b110, 8, 1, "R4", "R6");    // -8-1 overflows
        apply(3'b110, 7, 15, "R4", "R6");   // 7-(-1) overflows
        apply(3'b110, 5, 5, "R4", "R6");    // zero difference
        apply(3'b111, 8, 7, "R5", "R7");    // -8 < 7 with overflowed difference
        apply(3'b111, 7, 8, "R5", "R7");    // 7 < -8 false
        apply(3'b001, 15, 15, "R2", "R7");
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_idle();
        t_and();
        t_or();
        t_add();
        t_sub();
        t_slt();
        t_unused();
        t_corners();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule